// File: doc/BRIEF.md
# Nibble-Mode Reverse Byte Receiver

This block is the host side of a reverse (peripheral-to-host) parallel-port transfer that runs after nibble mode has been agreed. Each byte arrives as two 4-bit halves on the peripheral's status lines. For every half, the host lowers its request line (the auto-feed line), waits for the peripheral to pull the acknowledge line low, latches the four status lines, and then releases the request. It waits for acknowledge to return high before it issues the next request. The two strobe-type host lines that play no part in this phase are held high throughout.

A transfer starts with a one-cycle `start` pulse that carries the byte count on `reqLen`. Each assembled byte is offered on a valid/ready stream. The block holds one byte at a time and stops issuing requests while the consumer is not ready. At the end of a transfer, `doneValid` pulses for one cycle. It is accompanied by a status code and by the number of bytes the consumer accepted. Timeouts are measured in ticks, and one tick is `TICK_DIV` clock cycles. The first half of each byte is given a long idle allowance. Every other wait is given a short response allowance.

Top module: `nibble_rx`

## Requirements
- R1: After reset, `hostReqN`, `selInN` and `strobeN` are high, and `byteValid` and `doneValid` are low.
- R2: For each half-byte, `hostReqN` goes low while `selInN` and `strobeN` stay high. It returns high once a low `ackN` has been seen. A new request is made only after `ackN` has been seen high again.
- R3: Half-byte bit mapping, where a bit is 1 when its line is high: bit 0 = `faultN`, bit 1 = `selectIn`, bit 2 = `paperErr`, bit 3 = `busyIn`.
- R4: The first half captured for a byte becomes `byteData[3:0]`. The second half becomes `byteData[7:4]`.
- R5: The wait for `ackN` low on the first half of a byte lasts at most `IDLE_LIMIT` ticks. Every other wait lasts at most `RESP_LIMIT` ticks. One tick is `TICK_DIV` clock cycles.
- R6: The transfer ends with status 1 (timeout) in three cases: either wait of the first half expires, or the `ackN`-low wait of the second half expires.
- R7: If `ackN` fails to return high after the second half of a byte, the transfer ends with status 2 (I/O error). That byte is not delivered.
- R8: A byte is presented only after both halves are complete. While `byteReady` is low, `byteValid` and `byteData` hold steady and no new request is issued.
- R9: `doneValid` pulses for one cycle at the end of every transfer, and `doneCount` equals the number of bytes accepted. After `reqLen` bytes, the status is 0 (ok).
- R10: A `start` with `reqLen` = 0 finishes at once with status 0 and count 0. No request is issued.
- R11: A `start` pulse that arrives while a transfer is active (`active` high) has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| reqLen | input | CNT_W | Number of bytes to read |
| hostReqN | output | 1 | Host request / handshake line (auto-feed) |
| selInN | output | 1 | Select-in line, held high |
| strobeN | output | 1 | Strobe line, held high |
| ackN | input | 1 | Peripheral acknowledge |
| faultN | input | 1 | Status line, data bit 0 |
| selectIn | input | 1 | Status line, data bit 1 |
| paperErr | input | 1 | Status line, data bit 2 |
| busyIn | input | 1 | Status line, data bit 3 |
| byteValid | output | 1 | Assembled byte available |
| byteData | output | 8 | Assembled byte |
| byteReady | input | 1 | Consumer accepts byte |
| doneValid | output | 1 | Transfer finished (one-cycle pulse) |
| doneStatus | output | 2 | 0 ok, 1 timeout, 2 I/O error |
| doneCount | output | CNT_W | Bytes delivered in the transfer |
| active | output | 1 | Transfer in progress |

## Verification
The bench drives several kinds of byte patterns:
- A walking-one byte pattern, which separates the four bit positions and shows which half of the byte each lands in.
- Random bytes with random lengths and random consumer back-pressure, which show that bytes are neither lost nor duplicated while the block stalls.

It also injects peripheral faults:
- A silent peripheral on the first half and on the second half. Comparing how long each takes to give up tells the long limit apart from the short one.
- A peripheral that answers slowly on the first half. This must still succeed.
- An acknowledge stuck low after the second half. This is the one fault that must report an I/O error rather than a timeout.

Directed runs cover a zero-length request, a `start` pulse during an active transfer, and a long ready stall.

// File: rtl/nibble_rx_pkg.sv
package nibble_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RELEASE,
    ST_SHOW,
    ST_DONE
  } rxState_t;

  typedef enum logic [1:0] {
    RX_OK      = 2'd0,
    RX_TIMEOUT = 2'd1,
    RX_IOERR   = 2'd2
  } rxStatus_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic timerClr;  // restart the tick timer
    logic useLong;   // select the idle limit instead of the response limit
    logic capLo;     // latch status lines into low half
    logic capHi;     // latch status lines into high half
    logic lenLoad;   // latch request length, clear byte counter
    logic cntInc;    // one byte accepted by the consumer
  } rxCtrl_t;

endpackage

// File: rtl/nibble_rx_datapath.sv
module nibble_rx_datapath
  import nibble_rx_pkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int IDLE_LIMIT  = 2000,
  parameter int RESP_LIMIT  = 6,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxCtrl_t          ctrl,
  input  logic             ackRaw,
  input  logic [3:0]       statRaw,
  input  logic [CNT_W-1:0] reqLen,
  output logic             ackS,
  output logic             timeUp,
  output logic             lenZero,
  output logic             lastByte,
  output logic [7:0]       byteData,
  output logic [CNT_W-1:0] count
);

  localparam int TW = $clog2(IDLE_LIMIT + 1);
  localparam int DW = $clog2(TICK_DIV + 1);
  localparam logic [TW-1:0] LONG_LIM  = TW'(IDLE_LIMIT);
  localparam logic [TW-1:0] SHORT_LIM = TW'(RESP_LIMIT);
  localparam logic [DW-1:0] DIV_MAX   = DW'(TICK_DIV - 1);
  localparam int LW = 5;  // ack plus four status lines

  // ---------------- input synchronizer ----------------
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gen_sync
    logic [LW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= {1'b1, 4'b0000};
      end else begin
        if (g == 0) q <= {ackRaw, statRaw};
        else        q <= gen_sync[(g == 0) ? 0 : g - 1].q;
      end
    end
  end

  logic [LW-1:0] syncOut;
  logic [3:0]    statS;
  assign syncOut = gen_sync[SYNC_STAGES-1].q;
  assign ackS    = syncOut[4];
  assign statS   = syncOut[3:0];

  // ---------------- tick timer ----------------
  logic [DW-1:0] divQ;
  logic [TW-1:0] tickQ;

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.timerClr) begin
      divQ  <= '0;
      tickQ <= '0;
    end else if (divQ == DIV_MAX) begin
      divQ <= '0;
      if (tickQ != LONG_LIM) tickQ <= tickQ + 1'b1;
    end else begin
      divQ <= divQ + 1'b1;
    end
  end

  assign timeUp = tickQ >= (ctrl.useLong ? LONG_LIM : SHORT_LIM);

  // ---------------- byte assembly ----------------
  logic [3:0] loQ, hiQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loQ <= '0;
      hiQ <= '0;
    end else begin
      if (ctrl.capLo) loQ <= statS;
      if (ctrl.capHi) hiQ <= statS;
    end
  end

  assign byteData = {hiQ, loQ};

  // ---------------- length and count ----------------
  logic [CNT_W-1:0] lenQ, cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ <= '0;
      cntQ <= '0;
    end else if (ctrl.lenLoad) begin
      lenQ <= reqLen;
      cntQ <= '0;
    end else if (ctrl.cntInc) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign lenZero  = (reqLen == '0);
  assign lastByte = (CNT_W'(cntQ + 1'b1) == lenQ);
  assign count    = cntQ;

  // R9: no byte is accepted beyond the requested length
  p_no_overrun_r9 : assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cntInc |-> (cntQ < lenQ));

  // R4: a half is written into exactly one side of the byte
  p_cap_onehot_r4 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.capLo, ctrl.capHi}));

endmodule

// File: rtl/nibble_rx_ctrl.sv
module nibble_rx_ctrl
  import nibble_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      lenZero,
  input  logic      ackS,
  input  logic      timeUp,
  input  logic      lastByte,
  input  logic      byteReady,
  output rxCtrl_t   ctrl,
  output logic      hostReqN,
  output logic      byteValid,
  output logic      doneValid,
  output rxStatus_t doneStatus,
  output logic      active
);

  rxState_t  stateQ, stateNext;
  logic      hiQ, hiNext;
  rxStatus_t statQ, statNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      hiQ    <= 1'b0;
      statQ  <= RX_OK;
    end else begin
      stateQ <= stateNext;
      hiQ    <= hiNext;
      statQ  <= statNext;
    end
  end

  always_comb begin
    ctrl      = '0;
    stateNext = stateQ;
    hiNext    = hiQ;
    statNext  = statQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctrl.lenLoad = 1'b1;
          if (lenZero) begin
            statNext  = RX_OK;
            stateNext = ST_DONE;
          end else begin
            ctrl.timerClr = 1'b1;
            hiNext        = 1'b0;
            stateNext     = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        ctrl.useLong = !hiQ;
        if (!ackS) begin
          ctrl.capLo    = !hiQ;
          ctrl.capHi    = hiQ;
          ctrl.timerClr = 1'b1;
          stateNext     = ST_RELEASE;
        end else if (timeUp) begin
          statNext  = RX_TIMEOUT;
          stateNext = ST_DONE;
        end
      end
      ST_RELEASE: begin
        if (ackS) begin
          ctrl.timerClr = 1'b1;
          if (hiQ) begin
            stateNext = ST_SHOW;
          end else begin
            hiNext    = 1'b1;
            stateNext = ST_REQ;
          end
        end else if (timeUp) begin
          statNext  = hiQ ? RX_IOERR : RX_TIMEOUT;
          stateNext = ST_DONE;
        end
      end
      ST_SHOW: begin
        if (byteReady) begin
          ctrl.cntInc = 1'b1;
          if (lastByte) begin
            statNext  = RX_OK;
            stateNext = ST_DONE;
          end else begin
            ctrl.timerClr = 1'b1;
            hiNext        = 1'b0;
            stateNext     = ST_REQ;
          end
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign hostReqN   = (stateQ != ST_REQ);
  assign byteValid  = (stateQ == ST_SHOW);
  assign doneValid  = (stateQ == ST_DONE);
  assign doneStatus = statQ;
  assign active     = (stateQ != ST_IDLE);

  // R2: request is released the cycle after a low acknowledge is seen
  p_req_release_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_REQ && !ackS) |=> hostReqN);

  // R10: zero-length start finishes without a request
  p_zero_len_r10 : assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && start && lenZero) |=> (doneValid && hostReqN));

  // R6: an expired first-half wait ends with timeout status
  p_first_timeout_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_REQ && !hiQ && ackS && timeUp) |=> (doneValid && statQ == RX_TIMEOUT));

endmodule

// File: rtl/nibble_rx.sv
module nibble_rx
  import nibble_rx_pkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int IDLE_LIMIT  = 2000,
  parameter int RESP_LIMIT  = 6,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] reqLen,
  output logic             hostReqN,
  output logic             selInN,
  output logic             strobeN,
  input  logic             ackN,
  input  logic             faultN,
  input  logic             selectIn,
  input  logic             paperErr,
  input  logic             busyIn,
  output logic             byteValid,
  output logic [7:0]       byteData,
  input  logic             byteReady,
  output logic             doneValid,
  output logic [1:0]       doneStatus,
  output logic [CNT_W-1:0] doneCount,
  output logic             active
);

  rxCtrl_t   ctrl;
  logic      ackS, timeUp, lenZero, lastByte;
  rxStatus_t statusE;

  nibble_rx_datapath #(
    .TICK_DIV   (TICK_DIV),
    .IDLE_LIMIT (IDLE_LIMIT),
    .RESP_LIMIT (RESP_LIMIT),
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .ackRaw  (ackN),
    .statRaw ({busyIn, paperErr, selectIn, faultN}),
    .reqLen  (reqLen),
    .ackS    (ackS),
    .timeUp  (timeUp),
    .lenZero (lenZero),
    .lastByte(lastByte),
    .byteData(byteData),
    .count   (doneCount)
  );

  nibble_rx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .lenZero   (lenZero),
    .ackS      (ackS),
    .timeUp    (timeUp),
    .lastByte  (lastByte),
    .byteReady (byteReady),
    .ctrl      (ctrl),
    .hostReqN  (hostReqN),
    .byteValid (byteValid),
    .doneValid (doneValid),
    .doneStatus(statusE),
    .active    (active)
  );

  assign doneStatus = statusE;
  assign selInN     = 1'b1;
  assign strobeN    = 1'b1;

  // R8: an offered byte is held steady until taken
  p_byte_hold_r8 : assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !byteReady) |=> (byteValid && $stable(byteData)));

endmodule

// File: tb/nibble_rx_tb.sv
`timescale 1ns/1ps
module nibble_rx_tb;

  localparam int TICK_DIV = 4;
  localparam int IDLE_LIM = 2000;
  localparam int RESP_LIM = 6;
  localparam int CNT_W    = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] reqLen = '0;
  logic hostReqN, selInN, strobeN;
  logic ackN = 1'b1, faultN = 1'b0, selectIn = 1'b0, paperErr = 1'b0, busyIn = 1'b0;
  logic byteValid;
  logic [7:0] byteData;
  logic byteReady = 1'b1;
  logic doneValid;
  logic [1:0] doneStatus;
  logic [CNT_W-1:0] doneCount;
  logic active;

  always #5 clk = ~clk;

  nibble_rx #(.TICK_DIV(TICK_DIV), .IDLE_LIMIT(IDLE_LIM), .RESP_LIMIT(RESP_LIM),
              .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .reqLen(reqLen),
    .hostReqN(hostReqN), .selInN(selInN), .strobeN(strobeN),
    .ackN(ackN), .faultN(faultN), .selectIn(selectIn), .paperErr(paperErr), .busyIn(busyIn),
    .byteValid(byteValid), .byteData(byteData), .byteReady(byteReady),
    .doneValid(doneValid), .doneStatus(doneStatus), .doneCount(doneCount), .active(active)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  logic [7:0] perData [0:31];
  logic [7:0] got [0:31];
  int gotN = 0;
  int dropLowAt = -1, dropHighAt = -1, slowAt = -1, slowCycles = 0;
  int nibIdx = 0;
  bit perIdle = 1'b1;
  bit doneSeen = 1'b0;
  int doneSt = 0, doneCnt = 0, doneCyc = 0, lastFall = -1, fallCount = 0;
  int readyMode = 0;
  int pinViol = 0, ackViol = 0;
  logic prevHost = 1'b1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // consumer and monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      case (readyMode)
        0: byteReady = 1'b1;
        1: byteReady = ($urandom_range(0, 2) != 0);
        default: byteReady = 1'b0;
      endcase
      if (byteValid && byteReady && gotN < 32) begin
        got[gotN] = byteData;
        gotN++;
      end
      if (doneValid) begin
        doneSeen = 1'b1;
        doneSt   = int'(doneStatus);
        doneCnt  = int'(doneCount);
        doneCyc  = cyc;
      end
      if (prevHost && !hostReqN) begin
        lastFall = cyc;
        fallCount++;
        if (!ackN) ackViol++;
      end
      if (!hostReqN && (!strobeN || !selInN)) pinViol++;
      prevHost = hostReqN;
    end
  end

  // peripheral model
  initial begin
    logic [3:0] nib;
    int n, d;
    @(posedge rstN);
    forever begin
      perIdle = 1'b1;
      while (hostReqN !== 1'b0) @(negedge clk);
      perIdle = 1'b0;
      n = nibIdx;
      if (n == dropLowAt) begin
        while (hostReqN !== 1'b1) @(negedge clk);
      end else begin
        d = (n == slowAt) ? slowCycles : int'($urandom_range(1, 4));
        repeat (d) @(negedge clk);
        nib = n[0] ? perData[n >> 1][7:4] : perData[n >> 1][3:0];
        {busyIn, paperErr, selectIn, faultN} = nib;
        repeat (2) @(negedge clk);
        ackN = 1'b0;
        while (hostReqN !== 1'b1) @(negedge clk);
        if (n == dropHighAt) begin
          while (!doneSeen) @(negedge clk);
        end else begin
          repeat ($urandom_range(1, 3)) @(negedge clk);
        end
        ackN = 1'b1;
      end
      nibIdx++;
    end
  end

  // expected outcome from the fault configuration
  function automatic void expOutcome(input int len, output int eCnt, output int eSt);
    int lim;
    eCnt = len;
    eSt  = 0;
    for (int n = 0; n < 2 * len; n++) begin
      lim = (n % 2 == 0) ? IDLE_LIM * TICK_DIV : RESP_LIM * TICK_DIV;
      if (n == dropLowAt || (n == slowAt && slowCycles + 8 > lim)) begin
        eCnt = n / 2; eSt = 1; return;
      end
      if (n == dropHighAt) begin
        eCnt = n / 2; eSt = (n % 2 == 1) ? 2 : 1; return;
      end
    end
  endfunction

  task automatic startXfer(input int len);
    while (!(perIdle && ackN && !active)) @(negedge clk);
    repeat (2) @(negedge clk);
    gotN = 0; doneSeen = 1'b0; nibIdx = 0; lastFall = -1; fallCount = 0;
    start = 1'b1;
    reqLen = CNT_W'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finishXfer(input string req, input int len);
    int eCnt, eSt;
    expOutcome(len, eCnt, eSt);
    while (!doneSeen) @(negedge clk);
    chk(doneSt == eSt, req, "status", doneSt, eSt);
    chk(doneCnt == eCnt, "R9", "doneCount", doneCnt, eCnt);
    chk(gotN == eCnt, "R9", "bytes received", gotN, eCnt);
    for (int i = 0; i < eCnt && i < gotN; i++)
      chk(got[i] == perData[i], "R4", "byte value", int'(got[i]), int'(perData[i]));
    @(negedge clk);
    chk(hostReqN == 1'b1 && !active, "R9", "idle after done", int'(hostReqN), 1);
  endtask

  task automatic clearFaults();
    dropLowAt = -1; dropHighAt = -1; slowAt = -1; slowCycles = 0; readyMode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] hold;
    int stallBad;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(hostReqN == 1'b1, "R1", "hostReqN", int'(hostReqN), 1);
    chk(selInN == 1'b1 && strobeN == 1'b1, "R1", "selInN/strobeN", int'({selInN, strobeN}), 3);
    chk(!byteValid && !doneValid, "R1", "valid flags", int'({byteValid, doneValid}), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R3 walking ones, full ready
    clearFaults();
    for (int i = 0; i < 8; i++) perData[i] = 8'h01 << i;
    startXfer(8); finishXfer("R3", 8);
    chk(fallCount == 16, "R2", "requests per 8 bytes", fallCount, 16);

    // R4 distinct halves
    perData[0] = 8'hA5; perData[1] = 8'h3C; perData[2] = 8'hF0;
    startXfer(3); finishXfer("R4", 3);

    // random transfers with back-pressure
    for (int t = 0; t < 8; t++) begin
      int len;
      clearFaults();
      readyMode = 1;
      len = $urandom_range(1, 12);
      for (int i = 0; i < len; i++) perData[i] = 8'($urandom);
      startXfer(len); finishXfer("R8", len);
    end

    // R10 zero length
    clearFaults();
    startXfer(0); finishXfer("R10", 0);
    chk(fallCount == 0, "R10", "requests on zero length", fallCount, 0);

    // R5 slow first half tolerated by long limit
    clearFaults();
    for (int i = 0; i < 4; i++) perData[i] = 8'($urandom);
    slowAt = 2; slowCycles = 400;
    startXfer(4); finishXfer("R5", 4);

    // R5/R6 slow second half exceeds short limit
    clearFaults();
    slowAt = 3; slowCycles = 100;
    startXfer(4); finishXfer("R6", 4);

    // R6 silent on first half of byte 2, long limit timing
    clearFaults();
    dropLowAt = 4;
    startXfer(4); finishXfer("R6", 4);
    chk((doneCyc - lastFall) >= IDLE_LIM * TICK_DIV && (doneCyc - lastFall) <= IDLE_LIM * TICK_DIV + 6,
        "R5", "long wait cycles", doneCyc - lastFall, IDLE_LIM * TICK_DIV + 1);

    // R6 silent on second half, short limit timing
    clearFaults();
    dropLowAt = 1;
    startXfer(3); finishXfer("R6", 3);
    chk((doneCyc - lastFall) >= RESP_LIM * TICK_DIV && (doneCyc - lastFall) <= RESP_LIM * TICK_DIV + 6,
        "R5", "short wait cycles", doneCyc - lastFall, RESP_LIM * TICK_DIV + 1);

    // R6 ack stuck low after first half
    clearFaults();
    dropHighAt = 2;
    startXfer(3); finishXfer("R6", 3);

    // R7 ack stuck low after second half
    clearFaults();
    dropHighAt = 3;
    startXfer(3); finishXfer("R7", 3);

    // R8 long ready stall
    clearFaults();
    readyMode = 2;
    perData[0] = 8'h5A; perData[1] = 8'hC3;
    startXfer(2);
    while (!byteValid) @(negedge clk);
    hold = byteData;
    stallBad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!byteValid || byteData != hold || !hostReqN) stallBad++;
    end
    chk(stallBad == 0, "R8", "stall hold violations", stallBad, 0);
    chk(hold == 8'h5A, "R8", "stalled byte", int'(hold), 8'h5A);
    readyMode = 0;
    finishXfer("R8", 2);

    // R11 start during active transfer is ignored
    clearFaults();
    for (int i = 0; i < 8; i++) perData[i] = 8'($urandom);
    startXfer(3);
    repeat (10) @(negedge clk);
    start = 1'b1; reqLen = CNT_W'(7);
    @(negedge clk);
    start = 1'b0;
    finishXfer("R11", 3);

    chk(pinViol == 0, "R2", "strobe/select low during request", pinViol, 0);
    chk(ackViol == 0, "R2", "request while ack low", ackViol, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule